// File: doc/BRIEF.md
# Dual-Set Frame Alternation Controller

This controller paces frame processing across two identical processing sets, A and B. Each set holds a scoring engine and a list-building engine. In any one frame, the controller runs the list builder of one set and the scoring engine of the other. Each engine keeps its own memories wired to it, so the controller does not move data paths between sets. It only decides which engines are enabled, and this gives the ping-pong between the two sets.

A frame begins when the next input frame is announced as available. At that point each of the two chosen engines receives a single-cycle start pulse, and its enable stays high for the whole frame. The other two engines are held inactive. The frame ends only after both running engines have reported completion, in either order or in the same cycle. At that point the enables drop, the set roles swap for the next frame and the frame counter advances. Completion reports from held engines, or reports that arrive between frames, are discarded. Captured completions never carry over into a later frame.

Top module: `frame_alternation_ctrl`

## Requirements
- R1: While reset is held, and on leaving it, every enable and start output is 0, `phase` is 0 and `frame_count` is 0.
- R2: A frame starts only at a clock edge where the controller is not running a frame and `frame_avail` is 1. The enables of that frame go high in the cycle after that edge. While `frame_avail` stays 0 between frames, all enables stay 0.
- R3: In the first cycle of a frame, each of the two enabled engines sees exactly one start pulse. The pulse lasts one cycle and is never repeated within the frame.
- R4: Bit 0 of every two-bit vector port refers to set A and bit 1 to set B. With `phase` = 0, `build_en[0]` and `score_en[1]` are high. With `phase` = 1, `score_en[0]` and `build_en[1]` are high. The other two enables are held at 0.
- R5: A frame stays running until both the enabled scoring engine and the enabled list builder have raised their done input for at least one cycle. The two done inputs may arrive in either order or in the same cycle.
- R6: Done inputs from the two engines that are held inactive have no effect. Done inputs that arrive while no frame is running also have no effect.
- R7: When a frame completes, in the cycle after the edge that sampled the second done, all enables are 0, `phase` is inverted and `frame_count` has gone up by one.
- R8: `frame_count` counts completed frames modulo 2^CNT_W. It wraps from all ones to 0.
- R9: Completion flags are cleared at every frame boundary. A done that was seen in one frame does not count toward the next.
- R10: If `frame_avail` is still 1 when a frame completes, the next frame starts after exactly one cycle with all enables low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_avail | input | 1 | Next input frame is ready |
| score_done | input | 2 | Completion from the scoring engines (bit0 A, bit1 B) |
| build_done | input | 2 | Completion from the list builders (bit0 A, bit1 B) |
| score_en | output | 2 | Scoring engine enables |
| build_en | output | 2 | List builder enables |
| score_start | output | 2 | Single-cycle start pulses to the scoring engines |
| build_start | output | 2 | Single-cycle start pulses to the list builders |
| phase | output | 1 | Current role assignment (0: A builds, B scores) |
| frame_count | output | CNT_W | Completed frame count |

## Verification
A completion flag that is lost or stuck shows at the enables one cycle after the second done is sampled. A frame that should have ended stays enabled, or a frame ends after only one done. A stale flag left over from the previous frame makes the next frame end one cycle after a single done. A wrong phase register turns on the wrong pair of enables in the first cycle of the next frame. A start latch that does not clear shows as a second start cycle, one cycle after the first. Each scenario samples the ports the cycle after every stimulus, so a fault is seen within one frame of its cause.

// File: rtl/faf_pkg.sv
package faf_pkg;
  typedef enum logic [1:0] {
    FS_IDLE = 2'd0,
    FS_RUN  = 2'd1,
    FS_WAIT = 2'd2
  } fs_state_t;

  localparam int unsigned SET_CNT = 2;
  localparam int unsigned SET_A   = 0;
  localparam int unsigned SET_B   = 1;
endpackage

// File: rtl/faf_rst_sync.sv
module faf_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_sync = sync_q[1];
endmodule

// File: rtl/faf_sequencer.sv
module faf_sequencer
  import faf_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic frame_avail,
  input  logic frame_done,
  output logic run,
  output logic launch,
  output logic phase,
  output logic finish
);
  fs_state_t state_q, state_d;
  logic      phase_q, phase_d;
  logic      launch_q, launch_d;

  always_comb begin
    state_d  = state_q;
    phase_d  = phase_q;
    launch_d = 1'b0;
    case (state_q)
      FS_IDLE, FS_WAIT: begin
        if (frame_avail) begin
          state_d  = FS_RUN;
          launch_d = 1'b1;
        end
      end
      FS_RUN: begin
        if (frame_done) begin
          state_d = FS_WAIT;
          phase_d = ~phase_q;
        end
      end
      default: state_d = FS_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= FS_IDLE;
      phase_q  <= 1'b0;
      launch_q <= 1'b0;
    end else begin
      state_q  <= state_d;
      phase_q  <= phase_d;
      launch_q <= launch_d;
    end
  end

  assign run    = (state_q == FS_RUN);
  assign launch = launch_q;
  assign phase  = phase_q;
  assign finish = run & frame_done;

  AST_START_NEEDS_AVAIL: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(run) |-> $past(frame_avail)) else $error("frame began without input");  // R2
  AST_LAUNCH_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    launch |=> !launch) else $error("launch longer than one cycle");  // R3
  AST_PHASE_FLIPS_ON_END: assert property (@(posedge clk) disable iff (!rst_n)
    finish |=> (phase != $past(phase)) && !run) else $error("phase not swapped");  // R7
  AST_PHASE_HOLDS_IN_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !finish) |=> $stable(phase)) else $error("phase moved mid-frame");  // R4
endmodule

// File: rtl/faf_join.sv
module faf_join
  import faf_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               run,
  input  logic               phase,
  input  logic [SET_CNT-1:0] score_done,
  input  logic [SET_CNT-1:0] build_done,
  output logic               frame_done
);
  logic sc_seen_q, sc_seen_d;
  logic bl_seen_q, bl_seen_d;
  logic sc_hit, bl_hit;

  // phase 0: scoring in B, building in A; phase 1: the reverse
  assign sc_hit = phase ? score_done[SET_A] : score_done[SET_B];
  assign bl_hit = phase ? build_done[SET_B] : build_done[SET_A];

  assign frame_done = run & (sc_seen_q | sc_hit) & (bl_seen_q | bl_hit);

  always_comb begin
    sc_seen_d = run & ~frame_done & (sc_seen_q | sc_hit);
    bl_seen_d = run & ~frame_done & (bl_seen_q | bl_hit);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sc_seen_q <= 1'b0;
      bl_seen_q <= 1'b0;
    end else begin
      sc_seen_q <= sc_seen_d;
      bl_seen_q <= bl_seen_d;
    end
  end

  AST_FLAGS_CLEAR_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> !(sc_seen_q || bl_seen_q) || run) else $error("flag survived boundary");  // R9
  AST_NO_DOUBLE_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    !(sc_seen_q && bl_seen_q)) else $error("both flags held without end");  // R5
endmodule

// File: rtl/faf_roles.sv
module faf_roles
  import faf_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               run,
  input  logic               launch,
  input  logic               phase,
  output logic [SET_CNT-1:0] score_en,
  output logic [SET_CNT-1:0] build_en,
  output logic [SET_CNT-1:0] score_start,
  output logic [SET_CNT-1:0] build_start
);
  for (genvar s = 0; s < SET_CNT; s++) begin : g_set
    localparam logic SCORES_IN_PH1 = (s == SET_A);
    always_comb begin
      score_en[s]    = run & (phase == SCORES_IN_PH1);
      build_en[s]    = run & (phase != SCORES_IN_PH1);
      score_start[s] = launch & score_en[s];
      build_start[s] = launch & build_en[s];
    end

    AST_SET_ONE_ROLE: assert property (@(posedge clk) disable iff (!rst_n)
      !(score_en[s] && build_en[s])) else $error("set holds both roles");  // R4
  end

  AST_TWO_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> ($countones({score_en, build_en}) == 2)) else $error("wrong engine count");  // R4
endmodule

// File: rtl/faf_counter.sv
module faf_counter #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step,
  output logic [CNT_W-1:0] count
);
  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (step) cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cnt_q <= '0;
    else if (step) cnt_q <= cnt_d;
  end

  assign count = cnt_q;

  AST_COUNT_STEPS_BY_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q != $past(cnt_q)) |-> (cnt_q == $past(cnt_q) + 1'b1)) else $error("count jump");  // R8
endmodule

// File: rtl/frame_alternation_ctrl.sv
module frame_alternation_ctrl
  import faf_pkg::*;
#(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             frame_avail,
  input  logic [1:0]       score_done,
  input  logic [1:0]       build_done,
  output logic [1:0]       score_en,
  output logic [1:0]       build_en,
  output logic [1:0]       score_start,
  output logic [1:0]       build_start,
  output logic             phase,
  output logic [CNT_W-1:0] frame_count
);
  logic rst_n_i;
  logic run, launch, finish, frame_done;

  faf_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_i)
  );

  faf_sequencer u_seq (
    .clk         (clk),
    .rst_n       (rst_n_i),
    .frame_avail (frame_avail),
    .frame_done  (frame_done),
    .run         (run),
    .launch      (launch),
    .phase       (phase),
    .finish      (finish)
  );

  faf_join u_join (
    .clk        (clk),
    .rst_n      (rst_n_i),
    .run        (run),
    .phase      (phase),
    .score_done (score_done),
    .build_done (build_done),
    .frame_done (frame_done)
  );

  faf_roles u_roles (
    .clk         (clk),
    .rst_n       (rst_n_i),
    .run         (run),
    .launch      (launch),
    .phase       (phase),
    .score_en    (score_en),
    .build_en    (build_en),
    .score_start (score_start),
    .build_start (build_start)
  );

  faf_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk   (clk),
    .rst_n (rst_n_i),
    .step  (finish),
    .count (frame_count)
  );

  AST_RESET_QUIET: assert property (@(posedge clk)
    !rst_n_i |-> ({score_en, build_en, score_start, build_start} == 8'd0)) else $error("active in reset");  // R1
endmodule

// File: tb/sim_frame_alternation_ctrl.sv
module sim_frame_alternation_ctrl;
  localparam int CW = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          frame_avail = 1'b0;
  logic [1:0]    score_done = 2'b00;
  logic [1:0]    build_done = 2'b00;
  logic [1:0]    score_en, build_en, score_start, build_start;
  logic          phase;
  logic [CW-1:0] frame_count;

  int checks = 0;
  int fails  = 0;
  logic          exp_phase = 1'b0;
  logic [CW-1:0] exp_count = '0;
  bit            done_flag = 0;

  always #2 clk = ~clk;

  frame_alternation_ctrl #(.CNT_W(CW)) u0 (
    .clk(clk), .rst_n(rst_n), .frame_avail(frame_avail),
    .score_done(score_done), .build_done(build_done),
    .score_en(score_en), .build_en(build_en),
    .score_start(score_start), .build_start(build_start),
    .phase(phase), .frame_count(frame_count)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // expected {score_en, build_en} for a running frame in the given phase
  function automatic logic [3:0] run_en(input logic ph);
    return ph ? {2'b01, 2'b10} : {2'b10, 2'b01};
  endfunction

  task automatic launch_frame(input string req);
    frame_avail = 1'b1;
    @(negedge clk);
    frame_avail = 1'b0;
    chk({req, " enables at frame start"}, {score_en, build_en}, run_en(exp_phase));
    chk({req, " start pulses (R3)"}, {score_start, build_start}, run_en(exp_phase));
    @(negedge clk);
    chk("R3 start cleared", {score_start, build_start}, 4'd0);
  endtask

  task automatic pulse(input logic [1:0] sd, input logic [1:0] bd);
    score_done = sd;
    build_done = bd;
    @(negedge clk);
    score_done = 2'b00;
    build_done = 2'b00;
  endtask

  function automatic logic [1:0] act_sc(input logic ph);
    return ph ? 2'b01 : 2'b10;
  endfunction
  function automatic logic [1:0] act_bl(input logic ph);
    return ph ? 2'b10 : 2'b01;
  endfunction

  task automatic expect_done(input string req);
    exp_phase = ~exp_phase;
    exp_count = exp_count + 1'b1;
    chk({req, " enables drop"}, {score_en, build_en}, 4'd0);
    chk({req, " phase swap"}, phase, exp_phase);
    chk({req, " count step"}, frame_count, exp_count);
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk);
    chk("R1 outputs in reset", {score_en, build_en, score_start, build_start}, 8'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1 phase after reset", phase, 1'b0);
    chk("R1 count after reset", frame_count, 0);
    repeat (5) @(negedge clk);
    chk("R2 no frame without avail", {score_en, build_en}, 4'd0);
  endtask

  task automatic t_sequential_done();
    launch_frame("R2 R4 phase0");
    pulse(act_sc(exp_phase), 2'b00);
    chk("R5 still running after score only", {score_en, build_en}, run_en(exp_phase));
    @(negedge clk);
    chk("R5 still running, idle gap", {score_en, build_en}, run_en(exp_phase));
    pulse(2'b00, act_bl(exp_phase));
    expect_done("R7");
  endtask

  task automatic t_idle_ignored();
    launch_frame("R4 phase1");
    pulse(~act_sc(exp_phase), ~act_bl(exp_phase));
    chk("R6 idle done ignored", {score_en, build_en}, run_en(exp_phase));
    pulse(act_sc(exp_phase), act_bl(exp_phase));
    expect_done("R5 same-cycle");
  endtask

  task automatic t_between_frames();
    pulse(2'b11, 2'b11);
    chk("R6 no frame from done between frames", {score_en, build_en}, 4'd0);
    launch_frame("R6 after stray done");
    pulse(2'b00, act_bl(exp_phase));
    chk("R6 stray done not captured", {score_en, build_en}, run_en(exp_phase));
    pulse(act_sc(exp_phase), 2'b00);
    expect_done("R5 build first");
  endtask

  task automatic t_flag_clear();
    launch_frame("R9 frame a");
    pulse(act_sc(exp_phase), 2'b00);
    pulse(act_sc(exp_phase), act_bl(exp_phase));
    expect_done("R9 frame a end");
    launch_frame("R9 frame b");
    pulse(2'b00, act_bl(exp_phase));
    chk("R9 previous score flag gone", {score_en, build_en}, run_en(exp_phase));
    pulse(act_sc(exp_phase), 2'b00);
    expect_done("R9 frame b end");
  endtask

  task automatic t_back_to_back();
    frame_avail = 1'b1;
    @(negedge clk);
    chk("R10 frame begins", {score_en, build_en}, run_en(exp_phase));
    pulse(act_sc(exp_phase), act_bl(exp_phase));
    expect_done("R10");
    @(negedge clk);
    frame_avail = 1'b0;
    chk("R10 restart after one gap", {score_en, build_en}, run_en(exp_phase));
    chk("R10 restart start pulse", {score_start, build_start}, run_en(exp_phase));
    pulse(act_sc(exp_phase), act_bl(exp_phase));
    expect_done("R10 second");
  endtask

  task automatic t_wrap();
    for (int i = 0; i < 20; i++) begin
      launch_frame("R4 loop");
      pulse(act_sc(exp_phase), act_bl(exp_phase));
      expect_done("R8 wrap");
    end
  endtask

  initial begin
    #400000;
    fails++;
    $display("FAIL watchdog expired actual=timeout expected=finish");
    if (!done_flag) begin
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_sequential_done();
    t_idle_ignored();
    t_between_frames();
    t_flag_clear();
    t_back_to_back();
    t_wrap();
    done_flag = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule